// File: doc/BRIEF.md
# FPGA Slave Configuration Sequencer

This block loads a configuration image into one of two downstream programmable devices, called the main target and the mezzanine target. Each target has its own set of pins: an active-low program strobe, an open-drain INIT line with a hold control, a DONE input, an optional power or buffer enable, and a write strobe on a shared configuration data bus.

A start pulse selects a target. If that target is not fitted, the block reports at once and leaves every pin alone. If it is fitted, the block raises the target's enable, stops holding INIT low, holds the program strobe low for a set number of cycles and then waits for the target to raise INIT. It then moves the image bytes from a valid/ready stream onto the target's write port, in arrival order. After the last byte it waits for DONE. Each of the two waits has its own timeout. The block ends with a one-cycle finished pulse and a two-bit result code.

The program pulse width and both timeout limits are parameters. Which targets are fitted and which have an enable are also parameters.

Top module: `slave_cfg_seq`

## Requirements
- R1: After reset, busy_o, finished_o, byte_ready_o, en_o and result_o are all 0. prog_n_o is 2'b11 and init_hold_o is 2'b11, so INIT is held low on both targets.
- R2: A start to a target whose bit in TARGET_PRESENT is 0 gives finished_o in the next cycle with result_o = 1 (no configuration space). No prog_n_o, en_o, init_hold_o or cfg_wr_o bit changes.
- R3: When a sequence starts on target t, en_o[t] rises in the cycle after the start if TARGET_HAS_EN[t] is 1. Every en_o bit is 0 from the finished cycle onward, whatever the result.
- R4: From the cycle after a start to a fitted target t, init_hold_o[t] is 0 and it stays 0.
- R5: prog_n_o[t] is low for exactly PROG_LOW_CYC consecutive cycles, starting in the cycle after the start, and then returns high.
- R6: If INIT stays low for INIT_LIMIT polls after the program pulse, the sequence ends with result_o = 2 and no byte is written.
- R7: Once INIT is high, byte_ready_o is high only while bytes are still owed. Exactly size_i bytes are accepted on byte_valid_i && byte_ready_o. Each accepted byte appears on cfg_data_o with a one-cycle cfg_wr_o[t] strobe in the following cycle, in acceptance order.
- R8: If DONE stays low for DONE_LIMIT polls after the last byte, the sequence ends with result_o = 3.
- R9: If DONE rises in time, the sequence ends with result_o = 0. A size of 0 goes straight from the INIT wait to the DONE wait.
- R10: target_i (0 = main, 1 = mezzanine) chooses the pin set. No bit of prog_n_o, en_o or cfg_wr_o that belongs to the other target moves during the sequence.
- R11: busy_o is high from the cycle after an accepted start through the cycle in which finished_o pulses high for one cycle. A start while busy is ignored. result_o changes only in the finished cycle and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| target_i | input | 1 | Target select, 0 main, 1 mezzanine |
| size_i | input | SIZE_W | Image length in bytes, sampled at start |
| byte_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte valid |
| byte_ready_o | output | 1 | Block can take an image byte |
| prog_n_o | output | 2 | Active-low program strobe per target |
| init_hold_o | output | 2 | 1 drives INIT low, 0 releases it, per target |
| init_i | input | 2 | INIT level per target |
| done_i | input | 2 | DONE level per target |
| en_o | output | 2 | Enable line per target |
| cfg_wr_o | output | 2 | Configuration write strobe per target |
| cfg_data_o | output | 8 | Configuration write data |
| busy_o | output | 1 | Sequence in progress |
| finished_o | output | 1 | One-cycle end pulse |
| result_o | output | 2 | 0 ok, 1 no target, 2 INIT timeout, 3 DONE timeout |

## Verification
The bench sweeps both targets, image lengths from zero to four bytes, and three target behaviours: a target that responds on both lines, one whose INIT never rises, and one whose DONE never rises. These separate all four result codes and cover the zero-length shortcut. The input stream drops valid in a repeating pattern, so a byte that is lost, repeated or out of order shows up in the captured write sequence. A start is sent to the other target in the middle of every run, and the other target's pins are watched to confirm it is ignored. A second instance with the mezzanine target absent exercises the immediate "no target" exit.

// File: rtl/slave_cfg_seq.sv
module slave_cfg_seq #(
  parameter int unsigned PROG_LOW_CYC   = 20,
  parameter int unsigned INIT_LIMIT     = 10_000_000,
  parameter int unsigned DONE_LIMIT     = 100_000_000,
  parameter int unsigned SIZE_W         = 24,
  parameter logic [1:0]  TARGET_PRESENT = 2'b11,
  parameter logic [1:0]  TARGET_HAS_EN  = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              target_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic [1:0]        prog_n_o,
  output logic [1:0]        init_hold_o,
  input  logic [1:0]        init_i,
  input  logic [1:0]        done_i,
  output logic [1:0]        en_o,
  output logic [1:0]        cfg_wr_o,
  output logic [7:0]        cfg_data_o,
  output logic              busy_o,
  output logic              finished_o,
  output logic [1:0]        result_o
);
  localparam int unsigned LIM_A = (INIT_LIMIT > DONE_LIMIT) ? INIT_LIMIT : DONE_LIMIT;
  localparam int unsigned LIM   = (LIM_A > PROG_LOW_CYC) ? LIM_A : PROG_LOW_CYC;
  localparam int unsigned CNT_W = $clog2(LIM + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_NOCFG = 2'd1, RES_NOINIT = 2'd2, RES_NODONE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WINIT, S_DATA, S_WDONE, S_FIN} state_t;

  state_t            state;
  logic              tgt;
  logic [SIZE_W-1:0] size_q, nbytes;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        init_m, init_s, done_m, done_s;

  wire init_hi = init_s[tgt];
  wire done_hi = done_s[tgt];

  assign byte_ready_o = (state == S_DATA);
  assign busy_o       = (state != S_IDLE);
  assign finished_o   = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_m <= '0;
      init_s <= '0;
      done_m <= '0;
      done_s <= '0;
    end else begin
      init_m <= init_i;
      init_s <= init_m;
      done_m <= done_i;
      done_s <= done_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tgt         <= 1'b0;
      size_q      <= '0;
      nbytes      <= '0;
      cnt         <= '0;
      prog_n_o    <= 2'b11;
      init_hold_o <= 2'b11;
      en_o        <= 2'b00;
      cfg_wr_o    <= 2'b00;
      cfg_data_o  <= '0;
      result_o    <= RES_OK;
    end else begin
      cfg_wr_o <= 2'b00;
      case (state)
        S_IDLE: if (start_i) begin
          tgt    <= target_i;
          size_q <= size_i;
          nbytes <= '0;
          cnt    <= '0;
          if (!TARGET_PRESENT[target_i]) begin
            result_o <= RES_NOCFG;
            state    <= S_FIN;
          end else begin
            init_hold_o[target_i] <= 1'b0;
            prog_n_o[target_i]    <= 1'b0;
            en_o[target_i]        <= TARGET_HAS_EN[target_i];
            state                 <= S_PROG;
          end
        end
        S_PROG: begin
          if (cnt == CNT_W'(PROG_LOW_CYC - 1)) begin
            prog_n_o[tgt] <= 1'b1;
            cnt           <= '0;
            state         <= S_WINIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WINIT: begin
          if (init_hi) begin
            cnt   <= '0;
            state <= (size_q == '0) ? S_WDONE : S_DATA;
          end else if (cnt == CNT_W'(INIT_LIMIT - 1)) begin
            result_o <= RES_NOINIT;
            en_o     <= 2'b00;
            state    <= S_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (byte_valid_i) begin
          cfg_data_o    <= byte_i;
          cfg_wr_o[tgt] <= 1'b1;
          nbytes        <= nbytes + 1'b1;
          if (nbytes == size_q - 1'b1) begin
            cnt   <= '0;
            state <= S_WDONE;
          end
        end
        S_WDONE: begin
          if (done_hi) begin
            result_o <= RES_OK;
            en_o     <= 2'b00;
            state    <= S_FIN;
          end else if (cnt == CNT_W'(DONE_LIMIT - 1)) begin
            result_o <= RES_NODONE;
            en_o     <= 2'b00;
            state    <= S_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module slave_cfg_seq_chk #(
  parameter int unsigned PROG_LOW_CYC   = 20,
  parameter logic [1:0]  TARGET_PRESENT = 2'b11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       target_i,
  input logic       byte_ready_o,
  input logic [1:0] prog_n_o,
  input logic [1:0] init_hold_o,
  input logic [1:0] en_o,
  input logic [1:0] cfg_wr_o,
  input logic       busy_o,
  input logic       finished_o,
  input logic [1:0] result_o
);
  p_absent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !TARGET_PRESENT[target_i]) |=> (finished_o && result_o == 2'd1));

  p_en_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    finished_o |-> (en_o == 2'b00));

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && !finished_o));

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cfg_wr_o) <= 1) && (prog_n_o != 2'b00));

  p_fin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(finished_o));

  p_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !finished_o |-> $stable(result_o));

  for (genvar b = 0; b < 2; b++) begin : g_pin
    int unsigned low_run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_run <= 0;
      else if (!prog_n_o[b]) low_run <= low_run + 1;
      else low_run <= 0;
    end
    p_prog_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_n_o[b]) |-> (low_run == PROG_LOW_CYC));
    p_init_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(init_hold_o[b]));
  end
endmodule

bind slave_cfg_seq slave_cfg_seq_chk #(
  .PROG_LOW_CYC(PROG_LOW_CYC), .TARGET_PRESENT(TARGET_PRESENT)
) u_chk (.*);

// File: tb/test_slave_cfg_seq.sv
module test_slave_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PLOW = 4, ILIM = 8, DLIM = 12, SW = 8;
  localparam logic [1:0] HAS_EN = 2'b01;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          start = 0, target = 0, byte_valid = 0;
  logic [SW-1:0] size = 0;
  logic [7:0]    byte_d = 0;
  logic [1:0]    init_in = 0, done_in = 0;
  logic          byte_ready_o, busy_o, finished_o;
  logic [1:0]    prog_n_o, init_hold_o, en_o, cfg_wr_o, result_o;
  logic [7:0]    cfg_data_o;

  slave_cfg_seq #(.PROG_LOW_CYC(PLOW), .INIT_LIMIT(ILIM), .DONE_LIMIT(DLIM), .SIZE_W(SW),
                  .TARGET_PRESENT(2'b11), .TARGET_HAS_EN(HAS_EN)) i_slave_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target), .size_i(size),
    .byte_i(byte_d), .byte_valid_i(byte_valid), .byte_ready_o(byte_ready_o),
    .prog_n_o(prog_n_o), .init_hold_o(init_hold_o), .init_i(init_in), .done_i(done_in),
    .en_o(en_o), .cfg_wr_o(cfg_wr_o), .cfg_data_o(cfg_data_o),
    .busy_o(busy_o), .finished_o(finished_o), .result_o(result_o));

  logic       s_start = 0, s_ready, s_busy, s_fin;
  logic [1:0] s_prog, s_hold, s_en, s_wr, s_res;
  logic [7:0] s_data;
  slave_cfg_seq #(.PROG_LOW_CYC(PLOW), .INIT_LIMIT(ILIM), .DONE_LIMIT(DLIM), .SIZE_W(SW),
                  .TARGET_PRESENT(2'b01), .TARGET_HAS_EN(2'b11)) i_slave_cfg_seq_solo (
    .clk(clk), .rst_n(rst_n), .start_i(s_start), .target_i(1'b1), .size_i(8'd3),
    .byte_i(8'd0), .byte_valid_i(1'b0), .byte_ready_o(s_ready),
    .prog_n_o(s_prog), .init_hold_o(s_hold), .init_i(2'b11), .done_i(2'b11),
    .en_o(s_en), .cfg_wr_o(s_wr), .cfg_data_o(s_data),
    .busy_o(s_busy), .finished_o(s_fin), .result_o(s_res));

  int checks = 0, errors = 0;
  bit finished_run = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int t);
    return 8'(i * 37 + 11 + t * 100);
  endfunction

  int cur_t = 0, cur_size = 0, idx = 0, ncap = 0, cyc = 0;
  bit feeding = 0, prev_rdy = 0, done_arm = 0, mon_on = 0, other_moved = 0, saw_ready = 0;
  logic [7:0] cap [16];

  always @(negedge clk) begin
    cyc++;
    if (feeding) begin
      if (prev_rdy && byte_valid) idx++;
      prev_rdy = byte_ready_o;
      byte_d = pat(idx, cur_t);
      byte_valid = (idx < cur_size) && (cyc % 3 != 2);
    end else begin
      byte_valid = 0;
      prev_rdy = 0;
    end
    if (cfg_wr_o[cur_t] && ncap < 16) begin
      cap[ncap] = cfg_data_o;
      ncap++;
    end
    if (done_arm && ncap == cur_size && init_in[cur_t]) done_in[cur_t] = 1;
    if (mon_on) begin
      if (!prog_n_o[1-cur_t] || cfg_wr_o[1-cur_t] || en_o[1-cur_t]) other_moved = 1;
      if (byte_ready_o) saw_ready = 1;
    end
  end

  task automatic run(input int t, input int sz, input bit iok, input bit dok);
    int low;
    int exp;
    logic [1:0] r;
    exp = !iok ? 2 : (!dok ? 3 : 0);
    cur_t = t; cur_size = sz; ncap = 0; idx = 0;
    init_in = 0; done_in = 0; done_arm = dok; other_moved = 0; saw_ready = 0;
    @(negedge clk);
    start = 1; target = t[0]; size = SW'(sz); feeding = 1; mon_on = 1;
    @(negedge clk);
    start = 0;
    chk("R11 busy after start", busy_o, 1);
    chk("R3 enable raised", en_o[t], int'(HAS_EN[t]));
    chk("R4 INIT released", init_hold_o[t], 0);
    low = 0;
    while (prog_n_o[t] == 0 && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk("R5 program low width", low, PLOW);
    start = 1; target = ~t[0];
    @(negedge clk);
    start = 0;
    if (iok) begin
      repeat (2) @(negedge clk);
      init_in[t] = 1;
    end
    while (!finished_o) @(negedge clk);
    r = result_o;
    if (exp == 2) chk("R6 INIT timeout code", r, 2);
    else if (exp == 3) chk("R8 DONE timeout code", r, 3);
    else chk("R9 success code", r, 0);
    chk("R3 enable low at finish", en_o, 0);
    chk("R11 busy in finished cycle", busy_o, 1);
    @(negedge clk);
    chk("R11 busy drops", busy_o, 0);
    chk("R11 finished is one cycle", finished_o, 0);
    mon_on = 0; feeding = 0;
    chk("R10 other target untouched", other_moved, 0);
    if (iok) begin
      chk("R7 byte count", ncap, sz);
      for (int i = 0; i < sz; i++) chk("R7 byte order", cap[i], pat(i, t));
    end else begin
      chk("R6 no bytes written", ncap, 0);
      chk("R7 ready idle without INIT", saw_ready, 0);
    end
    repeat (2) @(negedge clk);
    chk("R11 result holds", result_o, r);
    init_in = 0; done_in = 0; done_arm = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 finished", finished_o, 0);
    chk("R1 ready", byte_ready_o, 0);
    chk("R1 prog_n", prog_n_o, 3);
    chk("R1 INIT hold", init_hold_o, 3);
    chk("R1 enable", en_o, 0);
    chk("R1 result", result_o, 0);
    rst_n = 1;
    @(negedge clk);
    s_start = 1;
    @(negedge clk);
    s_start = 0;
    chk("R2 finished at once", s_fin, 1);
    chk("R2 no-config code", s_res, 1);
    chk("R2 prog_n untouched", s_prog, 3);
    chk("R2 INIT hold untouched", s_hold, 3);
    chk("R2 enable untouched", s_en, 0);
    @(negedge clk);
    chk("R2 busy drops", s_busy, 0);
    chk("R2 no writes", s_wr, 0);
    for (int t = 0; t < 2; t++)
      for (int sz = 0; sz <= 4; sz++) begin
        run(t, sz, 1, 1);
        run(t, sz, 1, 0);
        run(t, sz, 0, 0);
      end
    finished_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule